// File: doc/BRIEF.md
# Two-Cell Pack Protection Controller

This block decides, cycle by cycle, whether a two-cell lithium pack may charge and whether it may discharge. Three comparator flags come in from the analog side: overvoltage, undervoltage and overcurrent. A fault flag changes an output only after it has stayed present for its own delay, which is counted in clock ticks.

Overvoltage and undervoltage are read only on a periodic sample strobe that the block makes itself. Overcurrent is watched every cycle. It first passes a short fixed filter and then its own delay. An external pack-disable input, together with a flag saying that input is not connected, forces the pack off. While the pack is forced off, the overcurrent timing is held at zero.

The charge output is a drive enable plus a data value, so a released, high-impedance state can be shown. The discharge output is always driven. The on-level of both outputs and the active level of the disable input are parameters. All are active-high by default.

Top module: `packProt`

## Requirements
- R1: With no qualified fault and the pack not disabled, `chgOe` is 1, `chgOut` is at the charge on-level (1 by default) and `dsgOut` is at the discharge on-level (1 by default).
- R2: While overvoltage is qualified and the pack is not disabled, `chgOe` is 0 and `chgOut` is 0 (charge high impedance), and `dsgOut` stays at its on-level.
- R3: While undervoltage or overcurrent is qualified and the pack is not disabled, `chgOe` is 1 with `chgOut` at its on-level, and `dsgOut` is at its off-level (0 by default).
- R4: When `disableUndriven` is 1, or `disableIn` is at its active level (1 by default), `chgOe` is 0 and `dsgOut` is at its off-level in that same cycle, whatever the fault flags are.
- R5: While the pack is disabled, the overcurrent timing is held at zero. After the disable is removed, with `ocFlag` still high, overcurrent qualifies only after a full `OC_FILT_TICKS + OC_DELAY_TICKS` rising edges.
- R6: Overcurrent qualifies on exactly the `OC_FILT_TICKS + OC_DELAY_TICKS`-th consecutive rising edge at which `ocFlag` is high. A single low cycle restarts the count, so a shorter burst never changes an output.
- R7: Overvoltage and undervoltage are sampled only on a strobe that comes every `SAMPLE_TICKS` cycles. The first strobe falls on the `SAMPLE_TICKS`-th edge after reset. A flag qualifies after it has been seen high for `OV_DELAY_TICKS` (or `UV_DELAY_TICKS`) consecutive edges. A flag that is sampled high on only one strobe, when that is fewer ticks than its delay, never changes an output.
- R8: A qualified overcurrent releases on the first edge at which `ocFlag` is low. A qualified overvoltage or undervoltage releases one edge after a strobe has sampled its flag low. The outputs then return to the R1 levels.
- R9: When overvoltage and overcurrent are both qualified, `chgOe` is 0 and `dsgOut` is at its off-level.
- R10: A synchronous `rst` clears every timer, every sampled flag and the strobe phase. Right after reset the outputs are at the R1 levels, even if a fault had been qualified before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ovFlag | input | 1 | Overvoltage comparator flag |
| uvFlag | input | 1 | Undervoltage comparator flag |
| ocFlag | input | 1 | Overcurrent comparator flag |
| disableIn | input | 1 | External pack disable |
| disableUndriven | input | 1 | Disable input is unconnected; forces the disabled state |
| chgOe | output | 1 | Charge output drive enable (0 = high impedance) |
| chgOut | output | 1 | Charge output value when driven |
| dsgOut | output | 1 | Discharge output |

## Verification
The bench measures the overcurrent path to the exact edge. A design with an off-by-one filter or delay count would change `dsgOut` one cycle early or late. A design that only gated the overcurrent flag during disable, instead of resetting the count, would fault straight away once the disable is released.

Overcurrent bursts one cycle short of the qualifying length, some broken by a single low cycle, catch a timer that keeps counting through gaps. An overvoltage pulse that spans a single strobe catches a design that latches a sampled flag, or that samples every cycle.

The bench also covers overvoltage and overcurrent together, the unconnected-disable path, and a reset taken during a qualified fault. Between them these expose a merged output decode and a timer that reset fails to clear.

// File: rtl/packProtPkg.sv
package packProtPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleStb;   // voltage flags are captured on this cycle
    logic ocHold;      // overcurrent timing forced to zero
  } ctlStrobes_t;

  // Qualified fault state from datapath to control
  typedef struct packed {
    logic ov;
    logic uv;
    logic oc;
  } faultQual_t;

endpackage

// File: rtl/persistTimer.sv
module persistTimer #(
  parameter int unsigned DELAY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic qual
);
  localparam int unsigned CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt;

  // qual rises on the DELAY-th consecutive edge with active high
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else if (cnt == LAST) begin
      qual <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  initial begin
    if (DELAY < 1) $error("persistTimer: DELAY must be at least 1");
  end
endmodule

// File: rtl/packProtDatapath.sv
module packProtDatapath
  import packProtPkg::*;
#(
  parameter int unsigned OV_DELAY_TICKS = 16,
  parameter int unsigned UV_DELAY_TICKS = 16,
  parameter int unsigned OC_FILT_TICKS  = 2,
  parameter int unsigned OC_DELAY_TICKS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ovFlag,
  input  logic        uvFlag,
  input  logic        ocFlag,
  input  ctlStrobes_t strobes,
  output faultQual_t  qual
);
  localparam int unsigned NV = 2;   // voltage channels: 0 = over, 1 = under

  logic [NV-1:0] vRaw;
  logic [NV-1:0] vSeen;
  logic [NV-1:0] vQual;

  assign vRaw = {uvFlag, ovFlag};

  // Sampled voltage channels, one delay per channel
  for (genvar i = 0; i < NV; i++) begin : g_volt
    localparam int unsigned DLY = (i == 0) ? OV_DELAY_TICKS : UV_DELAY_TICKS;

    always_ff @(posedge clk) begin
      if (rst)                    vSeen[i] <= 1'b0;
      else if (strobes.sampleStb) vSeen[i] <= vRaw[i];
    end

    persistTimer #(.DELAY(DLY)) u_vTimer (
      .clk   (clk),
      .rst   (rst),
      .active(vSeen[i]),
      .qual  (vQual[i])
    );
  end

  // Overcurrent: continuous, filter stage then delay stage
  logic ocLive;
  logic ocFiltered;
  logic ocQual;

  assign ocLive = ocFlag && !strobes.ocHold;

  persistTimer #(.DELAY(OC_FILT_TICKS)) u_ocFilt (
    .clk   (clk),
    .rst   (rst),
    .active(ocLive),
    .qual  (ocFiltered)
  );

  persistTimer #(.DELAY(OC_DELAY_TICKS)) u_ocDelay (
    .clk   (clk),
    .rst   (rst),
    .active(ocLive && ocFiltered),
    .qual  (ocQual)
  );

  assign qual.ov = vQual[0];
  assign qual.uv = vQual[1];
  assign qual.oc = ocQual;
endmodule

// File: rtl/packProtCtrl.sv
module packProtCtrl
  import packProtPkg::*;
#(
  parameter int unsigned SAMPLE_TICKS = 64,
  parameter bit          CHG_ON       = 1'b1,
  parameter bit          DSG_ON       = 1'b1,
  parameter bit          DIS_ACTIVE   = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        disableIn,
  input  logic        disableUndriven,
  input  faultQual_t  qual,
  output ctlStrobes_t strobes,
  output logic        chgOe,
  output logic        chgOut,
  output logic        dsgOut
);
  localparam int unsigned SW = (SAMPLE_TICKS < 2) ? 1 : $clog2(SAMPLE_TICKS);
  localparam logic [SW-1:0] SLAST = SW'(SAMPLE_TICKS - 1);

  logic [SW-1:0] sampleCnt;
  logic          packOff;
  logic          chgOff;
  logic          dsgOff;

  always_ff @(posedge clk) begin
    if (rst)                    sampleCnt <= '0;
    else if (sampleCnt == SLAST) sampleCnt <= '0;
    else                        sampleCnt <= sampleCnt + 1'b1;
  end

  assign packOff = disableUndriven || (disableIn == DIS_ACTIVE);

  assign strobes.sampleStb = (sampleCnt == SLAST);
  assign strobes.ocHold    = packOff;

  // Each fault only touches its own output; disable overrides both
  assign chgOff = packOff || qual.ov;
  assign dsgOff = packOff || qual.uv || qual.oc;

  assign chgOe  = !chgOff;
  assign chgOut = chgOff ? 1'b0 : CHG_ON;
  assign dsgOut = dsgOff ? !DSG_ON : DSG_ON;

  initial begin
    if (SAMPLE_TICKS < 1) $error("packProtCtrl: SAMPLE_TICKS must be at least 1");
  end
endmodule

// File: rtl/packProt.sv
module packProt
  import packProtPkg::*;
#(
  parameter int unsigned SAMPLE_TICKS   = 24000000,
  parameter int unsigned OV_DELAY_TICKS = 190000000,
  parameter int unsigned UV_DELAY_TICKS = 190000000,
  parameter int unsigned OC_FILT_TICKS  = 300000,
  parameter int unsigned OC_DELAY_TICKS = 2400000,
  parameter bit          CHG_ON         = 1'b1,
  parameter bit          DSG_ON         = 1'b1,
  parameter bit          DIS_ACTIVE     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ovFlag,
  input  logic uvFlag,
  input  logic ocFlag,
  input  logic disableIn,
  input  logic disableUndriven,
  output logic chgOe,
  output logic chgOut,
  output logic dsgOut
);
  ctlStrobes_t strobes;
  faultQual_t  qual;

  packProtCtrl #(
    .SAMPLE_TICKS(SAMPLE_TICKS),
    .CHG_ON      (CHG_ON),
    .DSG_ON      (DSG_ON),
    .DIS_ACTIVE  (DIS_ACTIVE)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .disableIn      (disableIn),
    .disableUndriven(disableUndriven),
    .qual           (qual),
    .strobes        (strobes),
    .chgOe          (chgOe),
    .chgOut         (chgOut),
    .dsgOut         (dsgOut)
  );

  packProtDatapath #(
    .OV_DELAY_TICKS(OV_DELAY_TICKS),
    .UV_DELAY_TICKS(UV_DELAY_TICKS),
    .OC_FILT_TICKS (OC_FILT_TICKS),
    .OC_DELAY_TICKS(OC_DELAY_TICKS)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ovFlag (ovFlag),
    .uvFlag (uvFlag),
    .ocFlag (ocFlag),
    .strobes(strobes),
    .qual   (qual)
  );
endmodule

// File: rtl/packProtChk.sv
module packProtChk #(
  parameter bit DSG_ON     = 1'b1,
  parameter bit DIS_ACTIVE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic ocFlag,
  input logic disableIn,
  input logic disableUndriven,
  input logic qOv,
  input logic qUv,
  input logic qOc,
  input logic chgOe,
  input logic dsgOut
);
  logic off;
  assign off = disableUndriven || (disableIn == DIS_ACTIVE);

  assert_normal_R1: assert property (@(posedge clk) disable iff (rst)
    (!off && !qOv && !qUv && !qOc) |-> (chgOe && dsgOut == DSG_ON));

  assert_ov_release_R2: assert property (@(posedge clk) disable iff (rst)
    (!off && qOv) |-> !chgOe);

  assert_disable_R4: assert property (@(posedge clk) disable iff (rst)
    off |-> (!chgOe && dsgOut == !DSG_ON));

  assert_oc_source_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(qOc) |-> ($past(ocFlag) && !$past(off)));

  assert_oc_release_R8: assert property (@(posedge clk) disable iff (rst)
    (qOc && !ocFlag) |=> !qOc);
endmodule

bind packProt packProtChk #(
  .DSG_ON    (DSG_ON),
  .DIS_ACTIVE(DIS_ACTIVE)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ocFlag         (ocFlag),
  .disableIn      (disableIn),
  .disableUndriven(disableUndriven),
  .qOv            (qual.ov),
  .qUv            (qual.uv),
  .qOc            (qual.oc),
  .chgOe          (chgOe),
  .dsgOut         (dsgOut)
);

// File: tb/packProt_tb.sv
`timescale 1ns/100ps
module packProt_tb;
  localparam int unsigned S_T  = 8;
  localparam int unsigned OVD  = 10;
  localparam int unsigned UVD  = 10;
  localparam int unsigned OCF  = 3;
  localparam int unsigned OCD  = 5;
  localparam int unsigned HOLD = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ovFlag = 0, uvFlag = 0, ocFlag = 0, disableIn = 0, disableUndriven = 0;
  logic chgOe, chgOut, dsgOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  packProt #(
    .SAMPLE_TICKS(S_T), .OV_DELAY_TICKS(OVD), .UV_DELAY_TICKS(UVD),
    .OC_FILT_TICKS(OCF), .OC_DELAY_TICKS(OCD)
  ) u_dut (
    .clk(clk), .rst(rst), .ovFlag(ovFlag), .uvFlag(uvFlag), .ocFlag(ocFlag),
    .disableIn(disableIn), .disableUndriven(disableUndriven),
    .chgOe(chgOe), .chgOut(chgOut), .dsgOut(dsgOut)
  );

  task automatic chk(input string req, input string what, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got oe/chg/dsg=%b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic logic [2:0] outs();
    return {chgOe, chgOut, dsgOut};
  endfunction

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // {ov, uv, oc, dis, undriven, expOe, expChg, expDsg}
  localparam logic [7:0] VEC [15] = '{
    8'b00000_111,  // R1 normal
    8'b10000_001,  // R2 overvoltage
    8'b00000_111,  // R8 release
    8'b01000_110,  // R3 undervoltage
    8'b00000_111,  // R8 release
    8'b00100_110,  // R3 overcurrent
    8'b00000_111,  // R8 release
    8'b10100_000,  // R9 ov + oc
    8'b00000_111,  // R1
    8'b00010_000,  // R4 disable
    8'b00001_000,  // R4 undriven
    8'b00000_111,  // R1
    8'b01010_000,  // R4 uv under disable
    8'b01000_110,  // R3 uv timer kept running
    8'b00000_111   // R8
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    edges(3);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10", "reset state", outs(), 3'b111);

    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      {ovFlag, uvFlag, ocFlag, disableIn, disableUndriven} = VEC[i][7:3];
      edges(HOLD);
      chk($sformatf("R1-R9 vec%0d", i), "table row", outs(), VEC[i][2:0]);
    end

    // R6: exact overcurrent qualification edge
    @(negedge clk); ocFlag = 1;
    edges(OCF + OCD - 1);
    chk("R6", "oc one edge short", outs(), 3'b111);
    edges(1);
    chk("R6", "oc qualified", outs(), 3'b110);
    // R8: release one edge after flag drops
    @(negedge clk); ocFlag = 0;
    edges(1);
    chk("R8", "oc released", outs(), 3'b111);

    // R6: bursts one short with a one-cycle gap never qualify
    begin
      logic [2:0] worst = 3'b111;
      for (int b = 0; b < 3; b++) begin
        @(negedge clk); ocFlag = 1;
        for (int k = 0; k < OCF + OCD - 1; k++) begin
          edges(1);
          if (dsgOut !== 1'b1) worst = outs();
        end
        @(negedge clk); ocFlag = 0;
        edges(1);
        if (dsgOut !== 1'b1) worst = outs();
      end
      chk("R6", "short oc bursts", worst, 3'b111);
    end

    // R4: disable acts in the same cycle
    @(negedge clk); disableIn = 1; #1;
    chk("R4", "disable immediate", outs(), 3'b000);

    // R5: oc timing held while disabled, restarts after release
    @(negedge clk); ocFlag = 1;
    edges(20);
    @(negedge clk); disableIn = 0;
    edges(OCF + OCD - 1);
    chk("R5", "oc restarted after disable", outs(), 3'b111);
    edges(1);
    chk("R5", "oc qualified after full count", outs(), 3'b110);
    @(negedge clk); ocFlag = 0;
    edges(2);

    // R7: ov pulse spanning a single strobe never qualifies
    begin
      logic [2:0] worst = 3'b111;
      @(negedge clk); ovFlag = 1;
      for (int k = 0; k < S_T; k++) begin
        edges(1);
        if (chgOe !== 1'b1) worst = outs();
      end
      @(negedge clk); ovFlag = 0;
      for (int k = 0; k < 3 * S_T + OVD; k++) begin
        edges(1);
        if (chgOe !== 1'b1) worst = outs();
      end
      chk("R7", "single-sample ov ignored", worst, 3'b111);
    end

    // R7: ov sampled high long enough qualifies
    @(negedge clk); ovFlag = 1;
    edges(S_T + OVD);
    chk("R7", "sustained ov qualifies", outs(), 3'b001);

    // R10: reset while faulted returns to normal
    @(negedge clk); rst = 1;
    edges(1);
    @(negedge clk); rst = 0; ovFlag = 0; #1;
    chk("R10", "reset clears fault", outs(), 3'b111);
    edges(S_T + 2);
    chk("R10", "stays normal after reset", outs(), 3'b111);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule